// File: doc/BRIEF.md
# Zero-Suppressing Multi-ASIC Readout Concentrator

The concentrator collects one bunch-train's worth of readout from a group of front-end ASICs on one module. After a train-start pulse it asks each ASIC in turn for its frame, one at a time. A frame is a bit-serial stream that carries two 14-bit words for every channel: an amplitude and a hit time counted in 50 ns steps. Each channel whose amplitude is above a programmable threshold becomes a hit. The hit is held in a small on-chip buffer together with its ASIC index and channel number.

When every ASIC has been read, the block sends the buffered hits on a valid/ready stream. The hits come out in bunch order: the bunch is the low five bits of the hit time. Each record carries the two data words, a 26-bit system-wide address and the train number. After the last hit it sends an end-of-train marker holding the hit count. Trains are handled strictly one after another, so the stream is ordered by train first and then by bunch. While the stream is stalled, no new ASIC frame is requested.

Top module: `zs_concentrator`

## Requirements
- R1: After reset, out_valid, fe_req, frame_err and ovf_err are all 0.
- R2: A train_start pulse is taken only while the block is idle. It latches train_num and then raises fe_req for ASIC 0, 1, … N_ASIC-1 in turn, with never more than one bit set. A train_start pulse at any other time has no effect.
- R3: While an ASIC is requested, one bit is taken per clock on its fe_data line whenever its fe_strobe is high. The bits arrive MSB first, 28 per channel, channels in ascending order. Bits 27:14 form the amplitude and bits 13:0 form the time word. The strobe and data lines of ASICs that are not requested have no effect.
- R4: A channel is a hit only when its amplitude is strictly greater than thr. An amplitude equal to thr is suppressed.
- R5: A hit record has out_marker=0 and out_data = {amplitude[13:0], time[13:0], CONC_ID[9:0], asic[3:0], channel[11:0]}. out_bunch is time[4:0] and out_train is the latched train number.
- R6: Within a train, records leave in ascending bunch order. Records with the same bunch leave in ascending ASIC order and then in ascending channel order. Every record of a train leaves before any record of the next train.
- R7: After the last hit record of a train comes one marker: out_marker=1, out_data equal to the number of hit records sent for that train, and out_bunch=0.
- R8: While out_valid is high and out_ready is low, the next cycle keeps out_valid high with out_data, out_bunch and out_marker unchanged. fe_req stays 0 from the end of a train's scan until its marker is accepted.
- R9: If the requested ASIC's strobe drops before all N_CHAN channels have arrived, the partial channel is discarded and the hits from complete channels are kept. frame_err is set and stays set until reset, and the scan moves on to the next ASIC.
- R10: Hits found while the buffer already holds BUF_DEPTH entries are discarded and not counted. ovf_err is then set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_start | input | 1 | Starts the scan of one train (taken when idle) |
| train_num | input | 16 | Train number, latched at train_start |
| thr | input | 14 | Amplitude threshold |
| fe_strobe | input | N_ASIC | Per-ASIC bit strobe, high while frame bits flow |
| fe_data | input | N_ASIC | Per-ASIC serial data, MSB first |
| fe_req | output | N_ASIC | One-hot request to the ASIC being read |
| out_valid | output | 1 | Output record valid |
| out_ready | input | 1 | Downstream accepts the record |
| out_data | output | 54 | Hit words plus address, or hit count in a marker |
| out_train | output | 16 | Train number of the record |
| out_bunch | output | 5 | Bunch index of the record |
| out_marker | output | 1 | Record is the end-of-train marker |
| frame_err | output | 1 | Sticky: a frame ended early |
| ovf_err | output | 1 | Sticky: a hit was lost to a full buffer |

## Verification
A misaligned deserializer bit counter would show up at the ports within the first train. The amplitude and time fields of every record would be shifted, and the hit count in the marker would change. A stuck or skipped ASIC index shows as a missing fe_req bit, or as records with the wrong ASIC field, before the end of that train. An error in the bunch scan or the buffer pointers breaks the record order or the marker count on the next emission. A stall that lets the read pointer move shows up the next cycle as a changed record while out_valid stays high.

// File: rtl/zs_conc_pkg.sv
package zs_conc_pkg;
    localparam int WORD_W     = 14;
    localparam int FRAME_BITS = 2 * WORD_W;
    localparam int ASIC_IDX_W = 4;
    localparam int CHAN_IDX_W = 12;
    localparam int CONC_ID_W  = 10;
    localparam int REC_W      = 2 * WORD_W + CONC_ID_W + ASIC_IDX_W + CHAN_IDX_W;
    localparam int TRAIN_W    = 16;
    localparam int BUNCH_W    = 5;

    typedef struct packed {
        logic [WORD_W-1:0]     amp;
        logic [WORD_W-1:0]     tim;
        logic [ASIC_IDX_W-1:0] asic;
        logic [CHAN_IDX_W-1:0] chan;
    } hit_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAIT,
        PH_RECV,
        PH_EMIT,
        PH_MARK
    } phase_e;
endpackage

// File: rtl/zs_deser.sv
module zs_deser
    import zs_conc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic              chan_done,
    output logic [WORD_W-1:0] word_amp,
    output logic [WORD_W-1:0] word_tim
);
    localparam int CNT_W = $clog2(FRAME_BITS);

    typedef struct packed {
        logic [FRAME_BITS-2:0] shreg;
        logic [CNT_W-1:0]      cnt;
    } ds_t;

    ds_t q, d;
    logic [FRAME_BITS-1:0] full;
    logic [CNT_W-1:0]      cnt_base;

    always_comb begin
        d         = q;
        full      = {q.shreg, bit_in};
        cnt_base  = restart ? '0 : q.cnt;
        chan_done = 1'b0;
        d.cnt     = cnt_base;
        if (shift_en) begin
            d.shreg = full[FRAME_BITS-2:0];
            if (cnt_base == CNT_W'(FRAME_BITS - 1)) begin
                chan_done = 1'b1;
                d.cnt     = '0;
            end else begin
                d.cnt = cnt_base + 1'b1;
            end
        end
        word_amp = full[FRAME_BITS-1:WORD_W];
        word_tim = full[WORD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/zs_hitbuf.sv
module zs_hitbuf
    import zs_conc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  hit_t             wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output hit_t             rd_data
);
    hit_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/zs_concentrator.sv
module zs_concentrator
    import zs_conc_pkg::*;
#(
    parameter int N_ASIC    = 12,
    parameter int N_CHAN    = 1024,
    parameter int BUF_DEPTH = 16,
    parameter logic [9:0] CONC_ID = 10'h000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               train_start,
    input  logic [15:0]        train_num,
    input  logic [13:0]        thr,
    input  logic [N_ASIC-1:0]  fe_strobe,
    input  logic [N_ASIC-1:0]  fe_data,
    output logic [N_ASIC-1:0]  fe_req,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [53:0]        out_data,
    output logic [15:0]        out_train,
    output logic [4:0]         out_bunch,
    output logic               out_marker,
    output logic               frame_err,
    output logic               ovf_err
);
    localparam int FILL_W = $clog2(BUF_DEPTH + 1);
    localparam int IDX_W  = $clog2(BUF_DEPTH);
    localparam logic [BUNCH_W-1:0] LAST_BUNCH = '1;

    typedef struct packed {
        phase_e                phase;
        logic [ASIC_IDX_W-1:0] asic;
        logic [CHAN_IDX_W-1:0] chan;
        logic [TRAIN_W-1:0]    train;
        logic [FILL_W-1:0]     fill;
        logic [IDX_W-1:0]      ridx;
        logic [BUNCH_W-1:0]    bunch;
        logic                  ferr;
        logic                  oerr;
    } ctl_t;

    ctl_t q, d;

    logic              sel_strobe, sel_bit;
    logic              ds_restart, ds_shift, ds_done;
    logic [WORD_W-1:0] ds_amp, ds_tim;
    logic              wr_en;
    hit_t              wr_hit, rd_hit;
    logic              match, advance;

    zs_deser u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (ds_restart),
        .shift_en (ds_shift),
        .bit_in   (sel_bit),
        .chan_done(ds_done),
        .word_amp (ds_amp),
        .word_tim (ds_tim)
    );

    zs_hitbuf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_idx (IDX_W'(q.fill)),
        .wr_data(wr_hit),
        .rd_idx (q.ridx),
        .rd_data(rd_hit)
    );

    always_comb begin
        d          = q;
        sel_strobe = 1'b0;
        sel_bit    = 1'b0;
        fe_req     = '0;
        ds_restart = 1'b0;
        ds_shift   = 1'b0;
        wr_en      = 1'b0;
        wr_hit     = '{amp: ds_amp, tim: ds_tim, asic: q.asic, chan: q.chan};
        out_valid  = 1'b0;
        out_marker = 1'b0;
        out_data   = '0;
        out_bunch  = '0;
        out_train  = q.train;
        match      = rd_hit.tim[BUNCH_W-1:0] == q.bunch;
        advance    = 1'b0;

        for (int i = 0; i < N_ASIC; i++) begin
            if (q.asic == ASIC_IDX_W'(i)) begin
                sel_strobe = fe_strobe[i];
                sel_bit    = fe_data[i];
                if (q.phase == PH_WAIT || q.phase == PH_RECV) fe_req[i] = 1'b1;
            end
        end

        unique case (q.phase)
            PH_IDLE: begin
                if (train_start) begin
                    d.phase = PH_WAIT;
                    d.train = train_num;
                    d.asic  = '0;
                    d.chan  = '0;
                    d.fill  = '0;
                end
            end
            PH_WAIT, PH_RECV: begin
                if (sel_strobe) begin
                    ds_shift   = 1'b1;
                    ds_restart = (q.phase == PH_WAIT);
                    d.phase    = PH_RECV;
                    if (ds_done) begin
                        if (ds_amp > thr) begin
                            if (q.fill < FILL_W'(BUF_DEPTH)) begin
                                wr_en  = 1'b1;
                                d.fill = q.fill + 1'b1;
                            end else begin
                                d.oerr = 1'b1;
                            end
                        end
                        if (q.chan == CHAN_IDX_W'(N_CHAN - 1)) advance = 1'b1;
                        else d.chan = q.chan + 1'b1;
                    end
                end else if (q.phase == PH_RECV) begin
                    d.ferr     = 1'b1;
                    ds_restart = 1'b1;
                    advance    = 1'b1;
                end
                if (advance) begin
                    d.chan = '0;
                    if (q.asic == ASIC_IDX_W'(N_ASIC - 1)) begin
                        d.phase = PH_EMIT;
                        d.ridx  = '0;
                        d.bunch = '0;
                    end else begin
                        d.asic  = q.asic + 1'b1;
                        d.phase = PH_WAIT;
                    end
                end
            end
            PH_EMIT: begin
                if (q.fill == '0) begin
                    d.phase = PH_MARK;
                end else begin
                    out_valid = match;
                    out_data  = {rd_hit.amp, rd_hit.tim, CONC_ID, rd_hit.asic, rd_hit.chan};
                    out_bunch = q.bunch;
                    if (!match || out_ready) begin
                        if (FILL_W'(q.ridx) == q.fill - 1'b1) begin
                            d.ridx = '0;
                            if (q.bunch == LAST_BUNCH) d.phase = PH_MARK;
                            else d.bunch = q.bunch + 1'b1;
                        end else begin
                            d.ridx = q.ridx + 1'b1;
                        end
                    end
                end
            end
            PH_MARK: begin
                out_valid  = 1'b1;
                out_marker = 1'b1;
                out_data   = REC_W'(q.fill);
                if (out_ready) d.phase = PH_IDLE;
            end
            default: d.phase = PH_IDLE;
        endcase

        frame_err = q.ferr;
        ovf_err   = q.oerr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{phase: PH_IDLE, default: '0};
        else        q <= d;
    end
endmodule

// File: rtl/zs_conc_checker.sv
module zs_conc_checker #(
    parameter int N_ASIC = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_ASIC-1:0] fe_req,
    input logic              out_valid,
    input logic              out_ready,
    input logic [53:0]       out_data,
    input logic [4:0]        out_bunch,
    input logic              out_marker,
    input logic              frame_err,
    input logic              ovf_err
);
    assert_req_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fe_req));

    assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_bunch) && $stable(out_marker));

    assert_no_scan_while_emit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> fe_req == '0);

    assert_marker_bunch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_marker |-> out_bunch == 5'd0);

    assert_frame_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);

    assert_ovf_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);
endmodule

bind zs_concentrator zs_conc_checker #(.N_ASIC(N_ASIC)) u_conc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fe_req    (fe_req),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_bunch (out_bunch),
    .out_marker(out_marker),
    .frame_err (frame_err),
    .ovf_err   (ovf_err)
);

// File: tb/zs_concentrator_tb_top.sv
`timescale 1ns/1ps
module zs_concentrator_tb_top;
    localparam int NA = 3;
    localparam int NC = 4;
    localparam int DEPTH = 8;
    localparam logic [9:0] CID = 10'h2A5;

    logic clk = 0;
    logic rst_n = 0;
    logic train_start = 0;
    logic [15:0] train_num = '0;
    logic [13:0] thr = '0;
    logic [NA-1:0] fe_strobe = '0;
    logic [NA-1:0] fe_data = '0;
    logic [NA-1:0] fe_req;
    logic out_valid, out_ready, out_marker, frame_err, ovf_err;
    logic [53:0] out_data;
    logic [15:0] out_train;
    logic [4:0]  out_bunch;

    always #10 clk = ~clk;

    zs_concentrator #(.N_ASIC(NA), .N_CHAN(NC), .BUF_DEPTH(DEPTH), .CONC_ID(CID)) dut_i (
        .clk(clk), .rst_n(rst_n), .train_start(train_start), .train_num(train_num),
        .thr(thr), .fe_strobe(fe_strobe), .fe_data(fe_data), .fe_req(fe_req),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_train(out_train), .out_bunch(out_bunch), .out_marker(out_marker),
        .frame_err(frame_err), .ovf_err(ovf_err)
    );

    int checks = 0;
    int fails  = 0;
    logic [75:0] expq [$];
    logic [13:0] amp_a [NA][NC];
    logic [13:0] tim_a [NA][NC];
    logic exp_ferr = 0, exp_oerr = 0;
    bit   bp_mode = 0;

    task automatic check(input bit ok, input string req, input logic [75:0] act, input logic [75:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // downstream ready, changed just after each rising edge
    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            out_ready = bp_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
        end
    end

    // record comparison and stall stability (R5, R6, R7, R8)
    logic [75:0] prev_rec;
    logic        stall_prev = 0;
    always @(negedge clk) begin
        logic [75:0] cur;
        cur = {out_marker, out_data, out_train, out_bunch};
        if (rst_n) begin
            if (stall_prev) check(out_valid && cur == prev_rec, "R8 stall hold", cur, prev_rec);
            if (out_valid) check(fe_req == '0, "R8 no request while emitting", 76'(fe_req), 76'd0);
            if (out_valid && out_ready) begin
                if (expq.size() == 0) check(1'b0, "R6 unexpected record", cur, 76'd0);
                else begin
                    logic [75:0] e;
                    e = expq.pop_front();
                    check(cur == e, e[75] ? "R7 marker" : "R5 R6 record", cur, e);
                end
            end
            stall_prev = out_valid && !out_ready;
            prev_rec   = cur;
        end
    end

    task automatic prep(input int s, input int base);
        for (int a = 0; a < NA; a++)
            for (int c = 0; c < NC; c++) begin
                amp_a[a][c] = 14'(base + ((a * 7 + c * 3 + s) % 10));
                tim_a[a][c] = 14'(((a * 13 + c * 7 + s * 5) % 32) | (((a + c + s) % 7) << 8));
            end
    endtask

    // behavioural model: collect hits in scan order, then stable sort by bunch
    task automatic build(input logic [15:0] tr, input logic [13:0] th, input int tr_a, input int tr_bits);
        logic [53:0] hits [$];
        int n = 0;
        for (int a = 0; a < NA; a++) begin
            int ncomp = (a == tr_a) ? tr_bits / 28 : NC;
            if (a == tr_a) exp_ferr = 1;
            for (int c = 0; c < ncomp; c++)
                if (amp_a[a][c] > th) begin
                    if (n < DEPTH) begin
                        hits.push_back({amp_a[a][c], tim_a[a][c], CID, 4'(a), 12'(c)});
                        n++;
                    end else exp_oerr = 1;
                end
        end
        for (int b = 0; b < 32; b++)
            foreach (hits[i])
                if (hits[i][30:26] == 5'(b)) expq.push_back({1'b0, hits[i], tr, 5'(b)});
        expq.push_back({1'b1, 54'(n), tr, 5'd0});
    endtask

    task automatic send_frame(input int a, input int nbits);
        while (fe_req[a] !== 1'b1) @(negedge clk);
        for (int k = 0; k < nbits; k++) begin
            logic [27:0] w;
            w = {amp_a[a][k / 28], tim_a[a][k / 28]};
            fe_strobe[a] = 1'b1;
            fe_data[a]   = w[27 - (k % 28)];
            @(negedge clk);
        end
        fe_strobe[a] = 1'b0;
        fe_data[a]   = 1'b0;
    endtask

    task automatic run_train(input logic [15:0] tr, input logic [13:0] th, input bit bp,
                             input int tr_a, input int tr_bits, input bit junk, input bit late_start);
        bp_mode = bp;
        thr = th;
        build(tr, th, tr_a, tr_bits);
        @(negedge clk);
        train_start = 1'b1;
        train_num = tr;
        @(negedge clk);
        train_start = 1'b0;
        train_num = 16'hDEAD;
        for (int a = 0; a < NA; a++) begin
            if (junk && a == 0) begin
                fe_strobe[NA-1] = 1'b1;   // R3: unselected ASIC noise
                fe_data[NA-1] = 1'b1;
            end
            send_frame(a, (a == tr_a) ? tr_bits : NC * 28);
            if (junk && a == 0) begin
                fe_strobe[NA-1] = 1'b0;
                fe_data[NA-1] = 1'b0;
            end
        end
        if (late_start) begin
            while (!out_valid) @(negedge clk);
            train_start = 1'b1;          // R2: ignored while emitting
            train_num = 16'hBEEF;
            @(negedge clk);
            train_start = 1'b0;
        end
        while (expq.size() != 0) @(negedge clk);
        repeat (4) begin
            @(negedge clk);
            check(fe_req == '0 && !out_valid, "R2 idle after marker", 76'({fe_req, out_valid}), 76'd0);
        end
        check(frame_err == exp_ferr, "R9 frame_err", 76'(frame_err), 76'(exp_ferr));
        check(ovf_err == exp_oerr, "R10 ovf_err", 76'(ovf_err), 76'(exp_oerr));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && fe_req == '0 && !frame_err && !ovf_err, "R1 reset state",
              76'({out_valid, fe_req, frame_err, ovf_err}), 76'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && fe_req == '0, "R1 idle after reset", 76'({out_valid, fe_req}), 76'd0);

        // R3 R4 R5 R6: amplitudes around threshold 100, ties suppressed
        prep(1, 95);
        run_train(16'h0011, 14'd100, 1'b0, -1, 0, 1'b0, 1'b0);
        // R8 R2 R3: backpressure, unselected noise, late train_start
        prep(4, 96);
        run_train(16'h1234, 14'd100, 1'b1, -1, 0, 1'b1, 1'b1);
        // R9: ASIC 1 frame stops mid channel 2
        prep(7, 97);
        run_train(16'h0203, 14'd100, 1'b0, 1, 61, 1'b0, 1'b0);
        // R10: every channel hits, buffer overflows
        prep(2, 500);
        run_train(16'hFFFE, 14'd100, 1'b1, -1, 0, 1'b0, 1'b0);
        // R7: no hits, marker with zero count
        prep(3, 10);
        run_train(16'h0007, 14'h3FFF, 1'b0, -1, 0, 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R6 watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule